// File: doc/BRIEF.md
# Mailbox Transmit Request Scheduler

This block keeps one pending-transmit flag per message mailbox and decides which mailbox is handed next to a frame transmitter. Software raises flags by writing a mask of ones. The transmitter answers with a completion or an abort pulse that names the mailbox. That pulse drops the flag and frees the scheduler to choose again. Software can read the whole flag vector back at any time.

Each mailbox has three inputs: a direction (transmit or receive), a remote-request enable and a priority level. A receive mailbox takes part in scheduling only when its remote-request enable is set, so that it can send a remote frame. The scheduler serves one mailbox at a time. The chosen index stays fixed until that mailbox is finished, so the transmitter never sees the selection move under it.

Top module: `txreq_sched`

## Requirements
- R1: After reset every request flag reads 0 and `sel_valid` is low.
- R2: A write with `cpu_we` high sets each flag whose bit in `cpu_wdata` is 1. Bits written as 0 leave their flags unchanged. `req_vec` shows the flags one cycle after the write edge.
- R3: When a single write sets several flags, every eligible flagged mailbox is offered exactly once, one after another.
- R4: A `tx_done` or `tx_abort` pulse whose `tx_idx` equals the index in service clears that flag and drops `sel_valid` after that edge.
- R5: If a write sets a flag in the same cycle that a completion clears it, the flag stays set and the mailbox is offered again.
- R6: A flagged mailbox with `mbx_is_rx` bit = 1 and `mbx_rtr` bit = 0 is never offered, and its flag remains set. With `mbx_rtr` = 1 it is offered, and its completion clears the flag.
- R7: Among eligible flagged mailboxes the one with the largest level is chosen. Mailbox i's 5-bit level sits in `mbx_prio[5*i+4:5*i]`.
- R8: Among eligible mailboxes with equal level, the highest mailbox number is chosen.
- R9: While `sel_valid` is high, `sel_idx` and `sel_valid` hold. A completion or abort pulse naming any other index has no effect on them or on the flags.
- R10: When the scheduler is idle and an eligible flag is pending at a clock edge, `sel_valid` rises at that edge. A flag written at edge k is therefore offered after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_we | input | 1 | Set-write strobe |
| cpu_wdata | input | 32 | Mask of flags to set |
| req_vec | output | 32 | Current request flags |
| mbx_is_rx | input | 32 | Per-mailbox direction, 1 = receive |
| mbx_rtr | input | 32 | Per-mailbox remote-request enable |
| mbx_prio | input | 160 | Per-mailbox 5-bit priority levels, packed |
| sel_valid | output | 1 | A mailbox is in service |
| sel_idx | output | 5 | Index of the mailbox in service |
| tx_done | input | 1 | Completion pulse from transmitter |
| tx_abort | input | 1 | Abort pulse from transmitter |
| tx_idx | input | 5 | Mailbox the pulse refers to |

## Verification
The hardest case to reach is a software set that lands in exactly the cycle in which the transmitter finishes the same mailbox. The bench gets there by waiting for that mailbox to be offered, then driving the completion pulse and a write of its bit on the same falling edge. It then expects the mailbox to be offered a second time. A completion that names the wrong index is produced the same way while a known mailbox is held in service. A receive mailbox is left pending for several idle cycles so the bench can show that it is skipped.

// File: rtl/txreq_pkg.sv
package txreq_pkg;
   typedef enum logic {
      SVC_IDLE = 1'b0,
      SVC_BUSY = 1'b1
   } svc_e;

   localparam int TXREQ_LEVEL_W_DEF = 5;
endpackage

// File: rtl/txreq_flags.sv
module txreq_flags #(
   parameter int NUM_MBX = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_we,
   input  logic [NUM_MBX-1:0] set_mask,
   input  logic [NUM_MBX-1:0] clr_mask,
   output logic [NUM_MBX-1:0] flags
);
   logic [NUM_MBX-1:0] set_eff;

   assign set_eff = set_we ? set_mask : '0;

   // set is applied after clear so a collision leaves the bit set
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags <= '0;
      else        flags <= (flags & ~clr_mask) | set_eff;
   end

   a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
      set_we |=> ((flags & $past(set_mask)) == $past(set_mask)));

   a_r2_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_we && clr_mask == '0) |=> $stable(flags));

   a_r5_only_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(flags) & ~flags) & ~$past(clr_mask)) == '0));
endmodule

// File: rtl/txreq_elig.sv
module txreq_elig #(
   parameter int NUM_MBX = 32
) (
   input  logic [NUM_MBX-1:0] flags,
   input  logic [NUM_MBX-1:0] is_rx,
   input  logic [NUM_MBX-1:0] rtr,
   output logic [NUM_MBX-1:0] elig
);
   for (genvar i = 0; i < NUM_MBX; i++) begin : g_mbx
      // transmit mailboxes always qualify; receive ones only for remote frames
      assign elig[i] = flags[i] & (~is_rx[i] | rtr[i]);
   end
endmodule

// File: rtl/txreq_pick.sv
module txreq_pick #(
   parameter int NUM_MBX   = 32,
   parameter int LEVEL_W   = 5,
   parameter bit PICK_TREE = 1'b1,
   localparam int IDX_W    = $clog2(NUM_MBX)
) (
   input  logic [NUM_MBX-1:0]         elig,
   input  logic [NUM_MBX*LEVEL_W-1:0] prio,
   output logic                       found,
   output logic [IDX_W-1:0]           idx
);
   localparam int NPAD   = 1 << IDX_W;
   localparam int LEVELS = IDX_W;

   if (PICK_TREE) begin : g_tree
      for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
         localparam int CNT = NPAD >> l;
         logic [CNT-1:0]     v;
         logic [LEVEL_W-1:0] p  [CNT];
         logic [IDX_W-1:0]   ix [CNT];
         if (l == 0) begin : g_leaf
            for (genvar n = 0; n < CNT; n++) begin : g_n
               if (n < NUM_MBX) begin : g_real
                  assign v[n] = elig[n];
                  assign p[n] = prio[n*LEVEL_W +: LEVEL_W];
               end else begin : g_pad
                  assign v[n] = 1'b0;
                  assign p[n] = '0;
               end
               assign ix[n] = IDX_W'(n);
            end
         end else begin : g_node
            for (genvar n = 0; n < CNT; n++) begin : g_n
               logic take_hi;
               // upper child has the larger index, so it wins ties
               assign take_hi = g_lvl[l-1].v[2*n+1] &&
                                (!g_lvl[l-1].v[2*n] ||
                                 g_lvl[l-1].p[2*n+1] >= g_lvl[l-1].p[2*n]);
               assign v[n]  = g_lvl[l-1].v[2*n+1] | g_lvl[l-1].v[2*n];
               assign p[n]  = take_hi ? g_lvl[l-1].p[2*n+1]  : g_lvl[l-1].p[2*n];
               assign ix[n] = take_hi ? g_lvl[l-1].ix[2*n+1] : g_lvl[l-1].ix[2*n];
            end
         end
      end
      assign found = g_lvl[LEVELS].v[0];
      assign idx   = g_lvl[LEVELS].ix[0];
   end else begin : g_scan
      logic               f_c;
      logic [LEVEL_W-1:0] bp_c;
      logic [IDX_W-1:0]   bi_c;
      always_comb begin
         f_c  = 1'b0;
         bp_c = '0;
         bi_c = '0;
         for (int i = 0; i < NUM_MBX; i++) begin
            if (elig[i] && (!f_c || prio[i*LEVEL_W +: LEVEL_W] >= bp_c)) begin
               f_c  = 1'b1;
               bp_c = prio[i*LEVEL_W +: LEVEL_W];
               bi_c = IDX_W'(i);
            end
         end
      end
      assign found = f_c;
      assign idx   = bi_c;
   end

   always_comb begin
      if (found) a_r6_pick_eligible: assert (elig[idx]);
      if (!found) a_r3_none_missed: assert (elig == '0);
   end
endmodule

// File: rtl/txreq_sched.sv
module txreq_sched #(
   parameter int NUM_MBX   = 32,
   parameter int LEVEL_W   = txreq_pkg::TXREQ_LEVEL_W_DEF,
   parameter bit PICK_TREE = 1'b1,
   localparam int IDX_W    = $clog2(NUM_MBX),
   localparam int PRIO_W   = NUM_MBX * LEVEL_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cpu_we,
   input  logic [NUM_MBX-1:0] cpu_wdata,
   output logic [NUM_MBX-1:0] req_vec,
   input  logic [NUM_MBX-1:0] mbx_is_rx,
   input  logic [NUM_MBX-1:0] mbx_rtr,
   input  logic [PRIO_W-1:0]  mbx_prio,
   output logic               sel_valid,
   output logic [IDX_W-1:0]   sel_idx,
   input  logic               tx_done,
   input  logic               tx_abort,
   input  logic [IDX_W-1:0]   tx_idx
);
   import txreq_pkg::*;

   if (NUM_MBX < 2) begin : g_chk_num
      $error("txreq_sched: NUM_MBX must be at least 2");
   end
   if (LEVEL_W < 1) begin : g_chk_lvl
      $error("txreq_sched: LEVEL_W must be at least 1");
   end

   svc_e               state;
   logic [IDX_W-1:0]   cur_idx;
   logic [NUM_MBX-1:0] flags;
   logic [NUM_MBX-1:0] elig;
   logic [NUM_MBX-1:0] clr_mask;
   logic               pick_found;
   logic [IDX_W-1:0]   pick_idx;
   logic               finish;

   txreq_flags #(.NUM_MBX(NUM_MBX)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_we   (cpu_we),
      .set_mask (cpu_wdata),
      .clr_mask (clr_mask),
      .flags    (flags)
   );

   txreq_elig #(.NUM_MBX(NUM_MBX)) u_elig (
      .flags (flags),
      .is_rx (mbx_is_rx),
      .rtr   (mbx_rtr),
      .elig  (elig)
   );

   txreq_pick #(
      .NUM_MBX   (NUM_MBX),
      .LEVEL_W   (LEVEL_W),
      .PICK_TREE (PICK_TREE)
   ) u_pick (
      .elig  (elig),
      .prio  (mbx_prio),
      .found (pick_found),
      .idx   (pick_idx)
   );

   assign finish = (state == SVC_BUSY) && (tx_done || tx_abort) && (tx_idx == cur_idx);

   for (genvar i = 0; i < NUM_MBX; i++) begin : g_clr
      assign clr_mask[i] = finish && (cur_idx == IDX_W'(i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= SVC_IDLE;
         cur_idx <= '0;
      end else begin
         case (state)
            SVC_IDLE: if (pick_found) begin
               state   <= SVC_BUSY;
               cur_idx <= pick_idx;
            end
            SVC_BUSY: if (finish) state <= SVC_IDLE;
            default:  state <= SVC_IDLE;
         endcase
      end
   end

   assign req_vec   = flags;
   assign sel_valid = (state == SVC_BUSY);
   assign sel_idx   = cur_idx;

   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_valid && !((tx_done || tx_abort) && tx_idx == sel_idx))
      |=> (sel_valid && $stable(sel_idx)));

   a_r6_in_service_pending: assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid |-> req_vec[sel_idx]);

   a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_valid && tx_done && tx_idx == sel_idx) |=> !sel_valid);

   a_r10_start: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_valid && (req_vec & (~mbx_is_rx | mbx_rtr)) != '0) |=> sel_valid);
endmodule

// File: tb/txreq_sched_test.sv
module txreq_sched_test;
   localparam int N  = 32;
   localparam int LW = 5;
   localparam int IW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_we = 1'b0;
   logic [N-1:0]  cpu_wdata = '0;
   logic [N-1:0]  req_vec;
   logic [N-1:0]  mbx_is_rx = '0;
   logic [N-1:0]  mbx_rtr = '0;
   logic [N*LW-1:0] mbx_prio = '0;
   logic          sel_valid;
   logic [IW-1:0] sel_idx;
   logic          tx_done = 1'b0;
   logic          tx_abort = 1'b0;
   logic [IW-1:0] tx_idx = '0;

   int total = 0;
   int bad = 0;
   int exp_q[$];
   bit finished = 1'b0;

   always #10 clk = ~clk;

   txreq_sched uut (
      .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
      .req_vec(req_vec), .mbx_is_rx(mbx_is_rx), .mbx_rtr(mbx_rtr),
      .mbx_prio(mbx_prio), .sel_valid(sel_valid), .sel_idx(sel_idx),
      .tx_done(tx_done), .tx_abort(tx_abort), .tx_idx(tx_idx)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cpu_set(input logic [N-1:0] m);
      @(negedge clk);
      cpu_we = 1'b1; cpu_wdata = m;
      @(negedge clk);
      cpu_we = 1'b0; cpu_wdata = '0;
   endtask

   task automatic set_level(input int i, input int lv);
      mbx_prio[i*LW +: LW] = LW'(lv);
   endtask

   // monitor side: wait for an offer, pop the expected index, compare, then finish it
   task automatic serve(input string req, input bit use_abort);
      int n = 0;
      int e;
      while (!sel_valid && n < 50) begin @(negedge clk); n++; end
      e = (exp_q.size() > 0) ? exp_q.pop_front() : -1;
      chk(sel_valid && sel_idx == IW'(e), req, {sel_valid, sel_idx}, {1'b1, IW'(e)});
      tx_idx = sel_idx; tx_done = !use_abort; tx_abort = use_abort;
      @(negedge clk);
      tx_done = 1'b0; tx_abort = 1'b0;
      chk(!sel_valid, "R4", sel_valid, 0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!finished) begin
         chk(1'b0, "watchdog", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(req_vec == '0 && !sel_valid, "R1", {req_vec, sel_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_vec == '0 && !sel_valid, "R1", {req_vec, sel_valid}, 0);

      // R2, R10, R3, R8: two flags at equal level
      @(negedge clk);
      cpu_we = 1'b1; cpu_wdata = 32'h0000_0005;
      @(negedge clk);
      cpu_we = 1'b0; cpu_wdata = '0;
      chk(req_vec == 32'h5, "R2", req_vec, 32'h5);
      chk(!sel_valid, "R10", sel_valid, 0);
      @(negedge clk);
      chk(sel_valid && sel_idx == 5'd2, "R10", {sel_valid, sel_idx}, {1'b1, 5'd2});
      cpu_set('0);
      chk(req_vec == 32'h5, "R2", req_vec, 32'h5);
      exp_q.push_back(2); exp_q.push_back(0);
      serve("R8", 1'b0);
      serve("R3", 1'b0);
      chk(req_vec == '0, "R3", req_vec, 0);

      // R7, R8: levels then index
      set_level(3, 7); set_level(10, 2); set_level(20, 7);
      cpu_set((32'h1 << 3) | (32'h1 << 10) | (32'h1 << 20));
      exp_q.push_back(20); exp_q.push_back(3); exp_q.push_back(10);
      serve("R8", 1'b0);
      serve("R7", 1'b0);
      serve("R7", 1'b0);
      set_level(3, 0); set_level(10, 0); set_level(20, 0);

      // R6: receive without remote enable is skipped
      mbx_is_rx[6] = 1'b1;
      cpu_set((32'h1 << 6) | 32'h2);
      exp_q.push_back(1);
      serve("R6", 1'b0);
      repeat (5) @(negedge clk);
      chk(!sel_valid && req_vec == (32'h1 << 6), "R6", {sel_valid, req_vec}, 32'h40);
      mbx_rtr[6] = 1'b1;
      exp_q.push_back(6);
      serve("R6", 1'b0);
      chk(req_vec == '0, "R6", req_vec, 0);
      mbx_is_rx[6] = 1'b0; mbx_rtr[6] = 1'b0;

      // R9: pulse for another index is ignored; R4: abort clears
      cpu_set(32'h1 << 9);
      @(negedge clk);
      chk(sel_valid && sel_idx == 5'd9, "R9", sel_idx, 9);
      tx_idx = 5'd4; tx_done = 1'b1;
      @(negedge clk);
      tx_done = 1'b0;
      chk(sel_valid && sel_idx == 5'd9 && req_vec == (32'h1 << 9), "R9",
          {sel_valid, sel_idx}, {1'b1, 5'd9});
      exp_q.push_back(9);
      serve("R4", 1'b1);
      chk(req_vec == '0, "R4", req_vec, 0);

      // R5: set and clear collide
      cpu_set(32'h1 << 12);
      @(negedge clk);
      chk(sel_valid && sel_idx == 5'd12, "R5", sel_idx, 12);
      tx_idx = 5'd12; tx_done = 1'b1; cpu_we = 1'b1; cpu_wdata = 32'h1 << 12;
      @(negedge clk);
      tx_done = 1'b0; cpu_we = 1'b0; cpu_wdata = '0;
      chk(!sel_valid && req_vec == (32'h1 << 12), "R5", {sel_valid, req_vec}, 32'h1000);
      exp_q.push_back(12);
      serve("R5", 1'b0);
      chk(req_vec == '0, "R5", req_vec, 0);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule